// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Byte Lanes

This block is a true dual-port static memory. Ports A and B each have their own clock and reset, and they can read or write any word at the same time, including the same word. Each port samples its address, write data, chip selects, byte-lane selects and read/write strobe on the rising edge of its own clock. Read data leaves through a data bus paired with a per-bit output-enable vector. This pair models a tri-state pad: a bit whose enable is 0 is undriven, and the block forces that data bit to 0.

A static mode pin on each port picks one of two read paths. In flow-through mode, read data is valid after the edge that samples the request. In pipelined mode it appears one edge later. In pipelined mode the chip selects go through two register stages, so both turning the outputs off and turning them back on lag by two edges. The byte-lane selects always go through a single stage. An output-enable input per port acts at once and needs no clock.

The word is split into an upper and a lower lane of equal width. A write updates only the selected lanes, and a read drives only the selected lanes. The intended user is a shared buffer between two clock domains, written and read in bursts.

Top module: `dpram_bytelane`

## Requirements
- R1: A port is selected only when `cs_n`=0 and `cs`=1. With either one inactive at an edge, that edge writes nothing, and the read path it controls drives no output bit.
- R2: Bit 1 of `lane_n` selects the upper lane, bits [DATA_W-1:DATA_W/2]. Bit 0 selects the lower lane, bits [DATA_W/2-1:0]. Both are active low. A write (`we_n`=0) on a selected port stores only the lanes whose select is 0, and the other lane keeps its old contents.
- R3: A read (`we_n`=1) sets `rdata_oe` to ones only on the lanes whose select is 0. With `lane_n`=2'b11 no bit is driven. Every undriven bit of `rdata` reads 0.
- R4: With `pipe`=0, read data for a request sampled at edge k is on `rdata` after edge k.
- R5: With `pipe`=1, read data for a request sampled at edge k is on `rdata` after edge k+1.
- R6: With `pipe`=1, the chip-select state sampled at edge k controls output drive after edge k+1, so deselecting and reselecting each take two edges. With `pipe`=0 it controls output drive after edge k.
- R7: In both modes, the lane selects sampled at edge k control which lanes are driven after edge k.
- R8: `oe_n`=1 forces `rdata_oe` and `rdata` to zero at once, without waiting for a clock edge. `oe_n`=0 restores the clocked drive state at once.
- R9: Both ports may address the same word in the same cycle. A read on one port in the cycle the other port writes that word returns the old contents, and the next read returns the new contents. Two simultaneous reads of one word return the same data.
- R10: A synchronous active-high reset clears the output state, so `rdata_oe` is zero after the reset edge. The array contents are not guaranteed across a reset.
- R11: A write cycle drives no output. It is delayed by the same number of stages as the chip selects in the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| pipe_a | input | 1 | Port A read path: 1 pipelined, 0 flow-through |
| cs_n_a | input | 1 | Port A chip select, active low |
| cs_a | input | 1 | Port A chip select, active high |
| we_n_a | input | 1 | Port A write strobe, 0 write, 1 read |
| lane_n_a | input | 2 | Port A lane selects, active low, bit 1 upper |
| oe_n_a | input | 1 | Port A asynchronous output enable, active low |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | DATA_W | Port A write data |
| rdata_a | output | DATA_W | Port A read data, 0 where undriven |
| rdata_oe_a | output | DATA_W | Port A per-bit drive enable |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| pipe_b | input | 1 | Port B read path: 1 pipelined, 0 flow-through |
| cs_n_b | input | 1 | Port B chip select, active low |
| cs_b | input | 1 | Port B chip select, active high |
| we_n_b | input | 1 | Port B write strobe, 0 write, 1 read |
| lane_n_b | input | 2 | Port B lane selects, active low, bit 1 upper |
| oe_n_b | input | 1 | Port B asynchronous output enable, active low |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | DATA_W | Port B write data |
| rdata_b | output | DATA_W | Port B read data, 0 where undriven |
| rdata_oe_b | output | DATA_W | Port B per-bit drive enable |

## Verification
A write on one port and a read of the same word on the other port can happen in the same cycle. The bench causes this by giving both ports the same address on one edge, once with A writing and B reading and once the other way round. The reference model takes every read before it applies any write of that edge. So the colliding read is expected to return the old word, and the read on the following edge is expected to return the new word. A second collision comes from a chip select changing while a lane select also changes in pipelined mode. There the bench expects the enable decision to lag two edges and the lane choice to lag one.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int LANES   = 2;
    localparam int LANE_HI = 1;
    localparam int LANE_LO = 0;

    // access state carried through the enable stages
    typedef struct packed {
        logic sel;
        logic rd;
    } acc_t;

    // each bank keeps one tag bit per lane and word; unequal tags mean bank B wrote last
    function automatic logic b_is_newer(input logic tag_of_a, input logic tag_of_b);
        return tag_of_a != tag_of_b;
    endfunction

    // tag a writer stores: A copies B's tag, B stores the inverse of A's tag
    function automatic logic stamp(input logic writer_is_b, input logic peer_tag);
        return writer_is_b ? ~peer_tag : peer_tag;
    endfunction

endpackage

// File: rtl/dpram_bank.sv
module dpram_bank
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic                      wclk,
    input  logic                      wrst,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES-1:0]          wen,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [LANES-1:0]          wtag,
    input  logic                      clk_a,
    input  logic [ADDR_W-1:0]         addr_a,
    output logic [LANES*LANE_W-1:0]   q_a,
    output logic [LANES-1:0]          tag_a,
    input  logic                      clk_b,
    input  logic [ADDR_W-1:0]         addr_b,
    output logic [LANES*LANE_W-1:0]   q_b,
    output logic [LANES-1:0]          tag_b
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic              tags  [DEPTH];
        logic [LANE_W-1:0] rd_a;
        logic [LANE_W-1:0] rd_b;

        always_ff @(posedge wclk) begin
            if (wen[l]) begin
                store[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge wclk) begin
            if (wrst) begin
                for (int i = 0; i < DEPTH; i++) begin
                    tags[i] <= 1'b0;
                end
            end else if (wen[l]) begin
                tags[waddr] <= wtag[l];
            end
        end

        // synchronous reads: a write on the same edge is not yet visible
        always_ff @(posedge clk_a) begin
            rd_a <= store[addr_a];
        end

        always_ff @(posedge clk_b) begin
            rd_b <= store[addr_b];
        end

        assign q_a[l*LANE_W +: LANE_W] = rd_a;
        assign q_b[l*LANE_W +: LANE_W] = rd_b;
        assign tag_a[l] = tags[addr_a];
        assign tag_b[l] = tags[addr_b];
    end

endmodule

// File: rtl/dpram_port.sv
module dpram_port
    import dpram_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int IS_B   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              we_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] q0,
    input  logic [DATA_W-1:0] q1,
    input  logic [LANES-1:0]  t0,
    input  logic [LANES-1:0]  t1,
    output logic [LANES-1:0]  wen,
    output logic [LANES-1:0]  wtag,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rdata_oe
);

    localparam int LANE_W = DATA_W / LANES;

    logic              sel_now;
    acc_t              st1;
    acc_t              st2;
    acc_t              act;
    logic [LANES-1:0]  lane_q;
    logic [LANES-1:0]  t0_q;
    logic [LANES-1:0]  t1_q;
    logic [DATA_W-1:0] flow_word;
    logic [DATA_W-1:0] word_q2;
    logic [DATA_W-1:0] word;
    logic [LANES-1:0]  lane_drive;

    assign sel_now = !cs_n && cs;
    assign wen     = (!rst && sel_now && !we_n) ? ~lane_n : '0;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (IS_B != 0) begin : g_b
            assign wtag[l] = stamp(1'b1, t0[l]);
        end else begin : g_a
            assign wtag[l] = stamp(1'b0, t1[l]);
        end
        assign flow_word[l*LANE_W +: LANE_W] = b_is_newer(t0_q[l], t1_q[l]) ?
                                               q1[l*LANE_W +: LANE_W] :
                                               q0[l*LANE_W +: LANE_W];
        assign rdata_oe[l*LANE_W +: LANE_W]  = {LANE_W{lane_drive[l]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st1     <= '0;
            st2     <= '0;
            lane_q  <= '0;
            t0_q    <= '0;
            t1_q    <= '0;
            word_q2 <= '0;
        end else begin
            st1     <= {sel_now, we_n};
            st2     <= st1;
            lane_q  <= ~lane_n;
            t0_q    <= t0;
            t1_q    <= t1;
            word_q2 <= flow_word;
        end
    end

    assign act        = pipe_mode ? st2 : st1;
    assign word       = pipe_mode ? word_q2 : flow_word;
    assign lane_drive = (!oe_n && act.sel && act.rd) ? lane_q : '0;
    assign rdata      = word & rdata_oe;

    AST_OE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (rdata_oe == '0)); // R8

    AST_FLOW_DESELECT_ONE: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !$past(sel_now)) |-> (lane_drive == '0)); // R1

    AST_PIPE_DESELECT_TWO: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && !$past(sel_now, 2)) |-> (lane_drive == '0)); // R6

    AST_FLOW_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !$past(we_n)) |-> (lane_drive == '0)); // R11

    AST_PIPE_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && !$past(we_n, 2)) |-> (lane_drive == '0)); // R11

    AST_LANE_SINGLE_STAGE: assert property (@(posedge clk) disable iff (rst)
        (|lane_drive) |-> ((lane_drive & $past(lane_n)) == '0)); // R7

endmodule

// File: rtl/dpram_bytelane.sv
module dpram_bytelane
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              pipe_a,
    input  logic              cs_n_a,
    input  logic              cs_a,
    input  logic              we_n_a,
    input  logic [1:0]        lane_n_a,
    input  logic              oe_n_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_oe_a,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              pipe_b,
    input  logic              cs_n_b,
    input  logic              cs_b,
    input  logic              we_n_b,
    input  logic [1:0]        lane_n_b,
    input  logic              oe_n_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] rdata_b,
    output logic [DATA_W-1:0] rdata_oe_b
);

    localparam int LANE_W = DATA_W / LANES;

    // q_v[bank][reader], tag_v[bank][reader]
    logic [DATA_W-1:0] q_v   [2][2];
    logic [LANES-1:0]  tag_v [2][2];
    logic [LANES-1:0]  wen_v  [2];
    logic [LANES-1:0]  wtag_v [2];

    for (genvar j = 0; j < 2; j++) begin : g_bank
        logic              wclk;
        logic              wrst;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;

        assign wclk  = (j == 0) ? clk_a   : clk_b;
        assign wrst  = (j == 0) ? rst_a   : rst_b;
        assign waddr = (j == 0) ? addr_a  : addr_b;
        assign wdata = (j == 0) ? wdata_a : wdata_b;

        dpram_bank #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) u_bank (
            .wclk   (wclk),
            .wrst   (wrst),
            .waddr  (waddr),
            .wen    (wen_v[j]),
            .wdata  (wdata),
            .wtag   (wtag_v[j]),
            .clk_a  (clk_a),
            .addr_a (addr_a),
            .q_a    (q_v[j][0]),
            .tag_a  (tag_v[j][0]),
            .clk_b  (clk_b),
            .addr_b (addr_b),
            .q_b    (q_v[j][1]),
            .tag_b  (tag_v[j][1])
        );
    end

    dpram_port #(
        .DATA_W (DATA_W),
        .IS_B   (0)
    ) u_port_a (
        .clk       (clk_a),
        .rst       (rst_a),
        .pipe_mode (pipe_a),
        .cs_n      (cs_n_a),
        .cs        (cs_a),
        .we_n      (we_n_a),
        .lane_n    (lane_n_a),
        .oe_n      (oe_n_a),
        .q0        (q_v[0][0]),
        .q1        (q_v[1][0]),
        .t0        (tag_v[0][0]),
        .t1        (tag_v[1][0]),
        .wen       (wen_v[0]),
        .wtag      (wtag_v[0]),
        .rdata     (rdata_a),
        .rdata_oe  (rdata_oe_a)
    );

    dpram_port #(
        .DATA_W (DATA_W),
        .IS_B   (1)
    ) u_port_b (
        .clk       (clk_b),
        .rst       (rst_b),
        .pipe_mode (pipe_b),
        .cs_n      (cs_n_b),
        .cs        (cs_b),
        .we_n      (we_n_b),
        .lane_n    (lane_n_b),
        .oe_n      (oe_n_b),
        .q0        (q_v[0][1]),
        .q1        (q_v[1][1]),
        .t0        (tag_v[0][1]),
        .t1        (tag_v[1][1]),
        .wen       (wen_v[1]),
        .wtag      (wtag_v[1]),
        .rdata     (rdata_b),
        .rdata_oe  (rdata_oe_b)
    );

endmodule

// File: tb/dpram_bytelane_tb.sv
`timescale 1ns/1ps
module dpram_bytelane_tb_top;

    localparam int AW    = 10;
    localparam int W     = 18;
    localparam int LW    = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic          pipe_t  [2];
    logic          cs_n_t  [2];
    logic          cs_t    [2];
    logic          we_n_t  [2];
    logic          oe_n_t  [2];
    logic [1:0]    lane_n_t[2];
    logic [AW-1:0] addr_t  [2];
    logic [W-1:0]  wdata_t [2];
    logic [W-1:0]  rdata_o [2];
    logic [W-1:0]  oe_o    [2];

    dpram_bytelane #(.ADDR_W(AW), .DATA_W(W)) dut_i (
        .clk_a(clk), .rst_a(rst), .pipe_a(pipe_t[0]), .cs_n_a(cs_n_t[0]), .cs_a(cs_t[0]),
        .we_n_a(we_n_t[0]), .lane_n_a(lane_n_t[0]), .oe_n_a(oe_n_t[0]), .addr_a(addr_t[0]),
        .wdata_a(wdata_t[0]), .rdata_a(rdata_o[0]), .rdata_oe_a(oe_o[0]),
        .clk_b(clk), .rst_b(rst), .pipe_b(pipe_t[1]), .cs_n_b(cs_n_t[1]), .cs_b(cs_t[1]),
        .we_n_b(we_n_t[1]), .lane_n_b(lane_n_t[1]), .oe_n_b(oe_n_t[1]), .addr_b(addr_t[1]),
        .wdata_b(wdata_t[1]), .rdata_b(rdata_o[1]), .rdata_oe_b(oe_o[1])
    );

    // behavioural reference model
    typedef struct packed {
        logic         sel;
        logic         rd;
        logic [W-1:0] data;
    } st_t;

    logic [W-1:0] ref_mem [DEPTH];
    st_t          s1 [2];
    st_t          s2 [2];
    logic [1:0]   lanes_m [2];

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_tag = "R10";

    always @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (rst) begin
                s1[p] = '0;
                s2[p] = '0;
                lanes_m[p] = 2'b00;
            end else begin
                s2[p] = s1[p];
                s1[p] = {!cs_n_t[p] && cs_t[p], we_n_t[p], ref_mem[addr_t[p]]};
                lanes_m[p] = ~lane_n_t[p];
            end
        end
        for (int p = 0; p < 2; p++) begin
            if (!rst && !cs_n_t[p] && cs_t[p] && !we_n_t[p]) begin
                if (!lane_n_t[p][0]) ref_mem[addr_t[p]][LW-1:0] = wdata_t[p][LW-1:0];
                if (!lane_n_t[p][1]) ref_mem[addr_t[p]][W-1:LW] = wdata_t[p][W-1:LW];
            end
        end
    end

    task automatic check_port(input int p);
        st_t        act;
        logic [1:0] d;
        logic [W-1:0] eoe;
        logic [W-1:0] edat;
        act = pipe_t[p] ? s2[p] : s1[p];
        for (int l = 0; l < 2; l++) begin
            d[l] = !oe_n_t[p] && act.sel && act.rd && lanes_m[p][l];
        end
        eoe  = {{LW{d[1]}}, {LW{d[0]}}};
        edat = act.data & eoe;
        checks++;
        if (rdata_o[p] !== edat || oe_o[p] !== eoe) begin
            fails++;
            $display("FAIL %s port %0d t=%0t: data=%h oe=%h expected data=%h oe=%h",
                     cur_tag, p, $time, rdata_o[p], oe_o[p], edat, eoe);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_port(0);
        check_port(1);
    endtask

    task automatic drive(input int p, input logic csn, input logic csh, input logic wen_n,
                         input logic [1:0] ln, input int a, input logic [W-1:0] d);
        cs_n_t[p]   = csn;
        cs_t[p]     = csh;
        we_n_t[p]   = wen_n;
        lane_n_t[p] = ln;
        addr_t[p]   = AW'(a);
        wdata_t[p]  = d;
    endtask

    task automatic idle(input int p);
        drive(p, 1'b1, 1'b0, 1'b1, 2'b11, 0, '0);
    endtask

    task automatic wr(input int p, input int a, input logic [W-1:0] d, input logic [1:0] ln);
        drive(p, 1'b0, 1'b1, 1'b0, ln, a, d);
    endtask

    task automatic rd(input int p, input int a, input logic [1:0] ln);
        drive(p, 1'b0, 1'b1, 1'b1, ln, a, '0);
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 32'h9e37) ^ 32'h2c5a3);
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        for (int p = 0; p < 2; p++) begin
            pipe_t[p] = 1'b0;
            oe_n_t[p] = 1'b0;
            idle(p);
        end
        // R10: nothing driven out of reset
        cur_tag = "R10";
        repeat (3) tick();
        rst = 1'b0;

        // R4: flow-through write then read
        cur_tag = "R4";
        for (int i = 0; i < 16; i++) begin
            wr(0, i, pat(i), 2'b00);
            idle(1);
            tick();
        end
        idle(0);
        for (int i = 0; i < 16; i++) begin
            rd(1, i, 2'b00);
            tick();
        end
        idle(1);
        tick();

        // R2: lane-limited writes
        cur_tag = "R2";
        wr(0, 3, 18'h3ffff, 2'b01);
        tick();
        wr(0, 4, 18'h00000, 2'b10);
        tick();
        idle(0);
        rd(1, 3, 2'b00);
        tick();
        rd(1, 4, 2'b00);
        tick();

        // R3: lane-limited reads
        cur_tag = "R3";
        rd(1, 3, 2'b01);
        tick();
        rd(1, 3, 2'b10);
        tick();
        rd(1, 3, 2'b11);
        tick();

        // R1: each chip select alone blocks writes and reads
        cur_tag = "R1";
        drive(0, 1'b1, 1'b1, 1'b0, 2'b00, 5, '0);
        rd(1, 9, 2'b00);
        tick();
        drive(0, 1'b0, 1'b0, 1'b0, 2'b00, 6, '0);
        drive(1, 1'b1, 1'b1, 1'b1, 2'b00, 5, '0);
        tick();
        drive(0, 1'b1, 1'b0, 1'b0, 2'b00, 7, '0);
        drive(1, 1'b0, 1'b0, 1'b1, 2'b00, 5, '0);
        tick();
        idle(0);
        for (int i = 5; i < 8; i++) begin
            rd(1, i, 2'b00);
            tick();
        end

        // R9: collisions between ports
        cur_tag = "R9";
        wr(0, 8, 18'h0aaaa, 2'b00);
        rd(1, 8, 2'b00);
        tick();
        idle(0);
        rd(1, 8, 2'b00);
        tick();
        wr(1, 9, 18'h15555, 2'b00);
        rd(0, 9, 2'b00);
        tick();
        rd(0, 9, 2'b00);
        idle(1);
        tick();
        rd(0, 10, 2'b00);
        rd(1, 10, 2'b00);
        tick();
        idle(1);

        // R11: flow-through write cycles stay quiet
        cur_tag = "R11";
        rd(0, 11, 2'b00);
        tick();
        wr(0, 12, pat(100), 2'b00);
        tick();
        rd(0, 12, 2'b00);
        tick();

        // R8: asynchronous output enable
        cur_tag = "R8";
        rd(0, 2, 2'b00);
        tick();
        oe_n_t[0] = 1'b1;
        #1;
        check_port(0);
        oe_n_t[0] = 1'b0;
        #1;
        check_port(0);
        oe_n_t[0] = 1'b1;
        tick();
        oe_n_t[0] = 1'b0;
        tick();
        idle(0);
        idle(1);
        tick();
        tick();

        // R5: pipelined reads
        cur_tag = "R5";
        pipe_t[0] = 1'b1;
        pipe_t[1] = 1'b1;
        tick();
        tick();
        for (int i = 0; i < 8; i++) begin
            rd(1, i, 2'b00);
            wr(0, 20 + i, pat(200 + i), 2'b00);
            tick();
        end
        idle(0);
        idle(1);
        tick();
        for (int i = 0; i < 8; i++) begin
            rd(0, 20 + i, 2'b00);
            tick();
        end
        idle(0);
        tick();
        tick();

        // R6: deselect/reselect lag, port A flow-through vs port B pipelined
        cur_tag = "R6";
        pipe_t[0] = 1'b0;
        tick();
        for (int p = 0; p < 2; p++) rd(p, 1, 2'b00);
        repeat (3) tick();
        for (int p = 0; p < 2; p++) drive(p, 1'b0, 1'b0, 1'b1, 2'b00, 1, '0);
        repeat (3) tick();
        for (int p = 0; p < 2; p++) rd(p, 1, 2'b00);
        repeat (3) tick();
        for (int p = 0; p < 2; p++) drive(p, 1'b1, 1'b1, 1'b1, 2'b00, 1, '0);
        tick();
        for (int p = 0; p < 2; p++) rd(p, 1, 2'b00);
        repeat (3) tick();

        // R7: lane selects take one stage in both modes
        cur_tag = "R7";
        for (int k = 0; k < 6; k++) begin
            for (int p = 0; p < 2; p++) rd(p, 2, 2'(k * 3 + 1));
            tick();
        end
        for (int p = 0; p < 2; p++) drive(p, 1'b1, 1'b1, 1'b1, 2'b01, 2, '0);
        tick();
        for (int p = 0; p < 2; p++) rd(p, 2, 2'b10);
        tick();
        tick();

        // R11: pipelined write cycles stay quiet
        cur_tag = "R11";
        idle(0);
        rd(1, 1, 2'b00);
        tick();
        wr(1, 13, pat(300), 2'b00);
        tick();
        rd(1, 13, 2'b00);
        tick();
        tick();
        idle(1);
        tick();
        tick();

        // R10: reset during reads clears the outputs
        cur_tag = "R10";
        rd(0, 1, 2'b00);
        rd(1, 2, 2'b00);
        tick();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        idle(0);
        idle(1);
        tick();
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule